// File: doc/BRIEF.md
# Handshake Word Bridge Between Clock Domains

This block carries a multi-bit word from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. The source side accepts a word with a valid input and copies it into a holding register. It then raises a request level. Only that request level crosses into the destination domain, through a chain of synchroniser flops. The destination sees the synchronised request rise and takes the held word into its output register. It then answers with an acknowledge level, which crosses back through a second synchroniser chain. The data bus itself never passes through synchroniser flops. It stays frozen in the holding register for as long as any part of the exchange is open.

The exchange has four phases. The source raises the request. The destination raises the acknowledge. The source drops the request. The destination drops the acknowledge. The source stays busy until it has seen the acknowledge return low, and only then does it accept another word. No word is lost or delivered twice. The cost is low throughput: each transfer takes several round trips through the synchronisers. Each domain has its own clock and its own synchronous active-low reset.

Top module: `hs_word_bridge`

## Requirements
- R1: While its domain reset is low, and on the first cycles after reset, src_busy and src_done read 0, dst_strobe reads 0 and dst_word reads all zeros. Every synchroniser flop is cleared by the reset of its own domain.
- R2: The request level falls only after the synchronised acknowledge has been seen high in the source domain. The acknowledge level falls only after the synchronised request has been seen low in the destination domain.
- R3: From the cycle a word is accepted until src_busy falls, the holding register keeps that word, whatever src_word does in the meantime.
- R4: A src_valid that is high while src_busy is 1 is ignored: it produces no transfer.
- R5: dst_word changes only in the cycle where dst_strobe is 1. dst_strobe is high for exactly one destination cycle per transfer, and dst_word then shows the accepted word.
- R6: src_done pulses for exactly one source cycle per transfer, when the synchronised acknowledge first rises. src_busy is still 1 during that pulse.
- R7: src_busy reads 1 in the source cycle after a word is accepted, and the request level is low whenever src_busy is 0. A word is accepted on a source edge where src_valid is 1 and src_busy is 0.
- R8: Every accepted word reaches dst_word exactly once, unchanged and in the order it was accepted.
- R9: The synchroniser depth is set by the parameter SYNC_STAGES, which must be 1 or more and defaults to 2. The word width is set by WORD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| src_valid | input | 1 | Offers src_word for transfer |
| src_word | input | WORD_W | Word offered by the source |
| src_busy | output | 1 | A transfer is in progress; new offers are ignored |
| src_done | output | 1 | One-cycle pulse when the destination has confirmed capture |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| dst_word | output | WORD_W | Last word delivered |
| dst_strobe | output | 1 | One-cycle pulse, aligned with a new dst_word |

## Verification
The bench builds the bridge with WORD_W = 16 and SYNC_STAGES = 3. The wider word lets a stray or stale capture show up as a value mismatch instead of an accidental match. The three-stage chains stretch each transfer to many cycles in both domains. That gives the bench time to keep valid asserted and keep changing src_word while a transfer is open, and to watch that the delivered word still equals the accepted one. The two clocks have periods of 8 ns and 11.7 ns, so the request and acknowledge edges land at shifting phases of the other clock over thousands of transfers.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_REQ   = 2'd1,
    SRC_DRAIN = 2'd2
  } src_state_t;

  // High in the single cycle where a level goes from 0 to 1.
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // A word is taken when offered while the source is idle.
  function automatic logic take_word(input logic valid_v, input logic busy_v);
    return valid_v & ~busy_v;
  endfunction

endpackage

// File: rtl/hsb_sync_chain.sv
module hsb_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) ff[0] <= 1'b0;
        else        ff[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) ff[i] <= 1'b0;
        else        ff[i] <= ff[i-1];
      end
    end
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/hsb_src_ctl.sv
module hsb_src_ctl
  import hsb_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic              ack_seen,
  output logic              req_lvl,
  output logic [WORD_W-1:0] hold_word,
  output logic              busy,
  output logic              done
);

  src_state_t state;
  logic       ack_seen_q;
  logic       accept;

  assign busy   = (state != SRC_IDLE);
  assign accept = take_word(valid, busy);
  assign done   = rise_of(ack_seen, ack_seen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ack_seen_q <= 1'b0;
    else        ack_seen_q <= ack_seen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SRC_IDLE;
      req_lvl   <= 1'b0;
      hold_word <= '0;
    end else begin
      case (state)
        SRC_IDLE: begin
          if (accept) begin
            hold_word <= word;
            req_lvl   <= 1'b1;
            state     <= SRC_REQ;
          end
        end
        SRC_REQ: begin
          if (ack_seen) begin
            req_lvl <= 1'b0;
            state   <= SRC_DRAIN;
          end
        end
        SRC_DRAIN: begin
          if (!ack_seen) state <= SRC_IDLE;
        end
        default: state <= SRC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hsb_dst_ctl.sv
module hsb_dst_ctl
  import hsb_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_seen,
  input  logic [WORD_W-1:0] hold_word,
  output logic              ack_lvl,
  output logic [WORD_W-1:0] out_word,
  output logic              strobe
);

  logic req_seen_q;
  logic first_high;

  assign first_high = rise_of(req_seen, req_seen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      ack_lvl    <= 1'b0;
      strobe     <= 1'b0;
      out_word   <= '0;
    end else begin
      req_seen_q <= req_seen;
      ack_lvl    <= req_seen;
      strobe     <= first_high;
      if (first_high) out_word <= hold_word;
    end
  end

endmodule

// File: rtl/hs_word_bridge.sv
module hs_word_bridge #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_word,
  output logic              src_busy,
  output logic              src_done,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [WORD_W-1:0] dst_word,
  output logic              dst_strobe
);

  localparam int CHAIN_LEN = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic              req_lvl;
  logic              ack_lvl;
  logic              req_seen_dst;
  logic              ack_seen_src;
  logic [WORD_W-1:0] hold_word;

  hsb_src_ctl #(.WORD_W(WORD_W)) u_src (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .valid     (src_valid),
    .word      (src_word),
    .ack_seen  (ack_seen_src),
    .req_lvl   (req_lvl),
    .hold_word (hold_word),
    .busy      (src_busy),
    .done      (src_done)
  );

  hsb_sync_chain #(.STAGES(CHAIN_LEN)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (req_lvl),
    .q     (req_seen_dst)
  );

  hsb_sync_chain #(.STAGES(CHAIN_LEN)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (ack_lvl),
    .q     (ack_seen_src)
  );

  hsb_dst_ctl #(.WORD_W(WORD_W)) u_dst (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .req_seen  (req_seen_dst),
    .hold_word (hold_word),
    .ack_lvl   (ack_lvl),
    .out_word  (dst_word),
    .strobe    (dst_strobe)
  );

endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int WORD_W = 8
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              src_busy,
  input logic              src_done,
  input logic              req_lvl,
  input logic              ack_seen_src,
  input logic [WORD_W-1:0] hold_word,
  input logic              ack_lvl,
  input logic              req_seen_dst,
  input logic              dst_strobe,
  input logic [WORD_W-1:0] dst_word
);

  AST_HOLD_FROZEN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_busy && $past(src_busy)) |-> $stable(hold_word)); // R3

  AST_REQ_DROP_AFTER_ACK: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(req_lvl) |-> $past(ack_seen_src)); // R2

  AST_ACK_DROP_AFTER_REQ: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(ack_lvl) |-> !$past(req_seen_dst)); // R2

  AST_STROBE_SINGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_strobe |=> !dst_strobe); // R5

  AST_WORD_ONLY_ON_STROBE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_strobe |-> $stable(dst_word)); // R5

  AST_DONE_SINGLE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_done |=> !src_done); // R6

  AST_DONE_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_done |-> src_busy); // R6

  AST_IDLE_NO_REQ: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_busy |-> !req_lvl); // R7

endmodule

bind hs_word_bridge hsb_checker #(.WORD_W(WORD_W)) u_hsb_checker (
  .src_clk      (src_clk),
  .src_rst_n    (src_rst_n),
  .dst_clk      (dst_clk),
  .dst_rst_n    (dst_rst_n),
  .src_busy     (src_busy),
  .src_done     (src_done),
  .req_lvl      (req_lvl),
  .ack_seen_src (ack_seen_src),
  .hold_word    (hold_word),
  .ack_lvl      (ack_lvl),
  .req_seen_dst (req_seen_dst),
  .dst_strobe   (dst_strobe),
  .dst_word     (dst_word)
);

// File: tb/test_hs_word_bridge.sv
`timescale 1ns/1ps
module test_hs_word_bridge;

  localparam int W  = 16;
  localparam int ST = 3;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst_n = 1'b0;
  logic         dst_rst_n = 1'b0;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_word = '0;
  logic         src_busy;
  logic         src_done;
  logic [W-1:0] dst_word;
  logic         dst_strobe;

  int n_chk = 0;
  int n_fail = 0;
  int n_acc = 0;
  int n_del = 0;
  int n_done = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_w;
  logic strobe_prev = 1'b0;
  logic done_prev = 1'b0;

  always #4 src_clk = ~src_clk;      // 125 MHz
  always #5.85 dst_clk = ~dst_clk;   // unrelated destination clock

  hs_word_bridge #(.WORD_W(W), .SYNC_STAGES(ST)) i_hs_word_bridge (
    .src_clk    (src_clk),
    .src_rst_n  (src_rst_n),
    .src_valid  (src_valid),
    .src_word   (src_word),
    .src_busy   (src_busy),
    .src_done   (src_done),
    .dst_clk    (dst_clk),
    .dst_rst_n  (dst_rst_n),
    .dst_word   (dst_word),
    .dst_strobe (dst_strobe)
  );

  function automatic bit offer_taken(logic v, logic b);
    return v && !b;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Destination monitor: R5 strobe width, R8 order and value
  always @(negedge dst_clk) begin
    if (dst_rst_n && !finished) begin
      if (dst_strobe) begin
        check(!strobe_prev, "R5 strobe lasts one cycle", W'(strobe_prev), '0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 word without accepted offer", dst_word, '0);
        end else begin
          exp_w = exp_q.pop_front();
          check(dst_word == exp_w, "R8 delivered word", dst_word, exp_w);
        end
        n_del++;
      end
      strobe_prev = dst_strobe;
    end
  end

  // Source monitor: R6 done pulse
  always @(negedge src_clk) begin
    if (src_rst_n && !finished) begin
      if (src_done) begin
        check(!done_prev, "R6 done lasts one cycle", W'(done_prev), '0);
        check(src_busy, "R6 busy during done", W'(src_busy), W'(1));
        n_done++;
      end
      done_prev = src_done;
    end
  end

  task automatic drive(logic v, logic [W-1:0] w);
    bit took;
    src_valid = v;
    src_word  = w;
    took = offer_taken(v, src_busy);
    if (took) begin
      exp_q.push_back(w);
      n_acc++;
    end
    @(negedge src_clk);
    if (took) check(src_busy == 1'b1, "R7 busy after accept", W'(src_busy), W'(1));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (10) @(negedge src_clk);
    // R1 reset state
    check(src_busy == 1'b0, "R1 busy in reset", W'(src_busy), '0);
    check(src_done == 1'b0, "R1 done in reset", W'(src_done), '0);
    check(dst_strobe == 1'b0, "R1 strobe in reset", W'(dst_strobe), '0);
    check(dst_word == '0, "R1 word in reset", dst_word, '0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    @(negedge src_clk);
    check(src_busy == 1'b0, "R1 busy after reset", W'(src_busy), '0);
    check(dst_word == '0, "R1 word after reset", dst_word, '0);

    // Directed corners: zero, all ones, alternating; valid held high with a
    // changing word (R3, R4)
    for (int k = 0; k < 40; k++) drive(1'b1, '0 ^ W'(k * 16'h0101));
    for (int k = 0; k < 40; k++) drive(1'b1, {W{1'b1}} ^ W'(k));
    for (int k = 0; k < 40; k++) drive(1'b1, {(W/2){2'b10}} ^ W'(k << 3));
    drive(1'b0, '0);

    // Constrained random traffic
    for (int c = 0; c < 20000; c++) begin
      int mode;
      mode = int'($urandom_range(0, 9));
      if (mode < 6) drive(1'b1, W'($urandom()));
      else          drive(1'b0, W'($urandom()));
    end

    src_valid = 1'b0;
    for (int c = 0; c < 400 && src_busy; c++) @(negedge src_clk);
    repeat (20) @(negedge dst_clk);
    @(negedge src_clk);
    check(src_busy == 1'b0, "R7 idle at end", W'(src_busy), '0);
    check(exp_q.size() == 0, "R8 all words delivered", W'(exp_q.size()), '0);
    check(n_del == n_acc, "R4 one transfer per accepted offer", W'(n_del), W'(n_acc));
    check(n_done == n_acc, "R6 one done per transfer", W'(n_done), W'(n_acc));
    check(n_acc > 100, "R9 transfers with three-stage chains", W'(n_acc), W'(101));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, R8 actual=%0d expected=%0d", n_del, n_acc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule